// File: doc/BRIEF.md
# E-Link Frame Serializer and Deserializer Bridge

This block connects a frame-oriented link core to a bank of serial front-end links. The downlink frame arrives once per 25 ns, at a 40 MHz frame rate. It is 80 bits wide. The block splits it into one small field per link and shifts each field out, most significant bit first, at single data rate on the link clock. The uplink runs in the other direction. Each link input is sampled on both edges of the link clock. The bits that arrive during one frame period are packed into a 112-bit uplink frame. That frame is registered once per frame period and marked with a one-cycle valid pulse.

The whole block runs on the link clock, which is `RATIO` times the frame clock (`RATIO` is 1 or 2). The `frame_stb` input is high in the first link-clock cycle of every frame. Because capture is at double data rate, each link returns `2*RATIO` bits per frame. By default the link count is ceil(112 / (2*RATIO)): 56 links at a 40 MHz link clock and 28 links at 80 MHz. For each link, a control bit selects whether a captured bit pair starts on the falling edge or on the rising edge. This lets the capture adapt to cable skew. Clock generation, phase stepping and fine input delays sit outside the block.

Top module: `elink_bridge`

## Requirements
- R1: With default parameters the link count is ceil(`UL_W` / (2*`RATIO`)). Link k takes its downlink field from `dl_frame[k*RATIO +: RATIO]`.
- R2: At the clock edge where `frame_stb` is sampled high, `elink_tx[k]` takes the most significant bit of link k's field. At each following edge it takes the next lower bit, so all `RATIO` bits go out in order, one per cycle.
- R3: After reset, and until the first `frame_stb` has been sampled, every `elink_tx` output is 0.
- R4: With `rx_order[k]` = 0 (rising first), the bits of link k for a frame starting in cycle s are, earliest first: rise(s), fall(s), rise(s+1), fall(s+1), and so on. rise(c) is the input at the rising edge that opens cycle c, and fall(c) is the input at the falling edge within cycle c.
- R5: With `rx_order[k]` = 1 (falling first), the bits of link k for a frame starting in cycle s are, earliest first: fall(s-1), rise(s), fall(s), rise(s+1), and so on.
- R6: The edge order of a frame is the value of `rx_order` sampled together with that frame's `frame_stb`. Changes to `rx_order` in the other cycles of the frame have no effect on that frame.
- R7: Link k's bits occupy `ul_frame[k*2*RATIO +: 2*RATIO]`, with the earliest bit in the most significant position. All bits at or above `N_LINKS*2*RATIO` are 0.
- R8: `ul_valid` is high for exactly one cycle, following the edge at which a frame-completing `frame_stb` is sampled. `ul_frame` changes only together with `ul_valid` and is otherwise held.
- R9: Synchronous active-low reset clears `ul_frame`, `ul_valid` and `elink_tx`. After reset, `ul_valid` stays low at the first `frame_stb` and first rises at the second one, when a whole frame has been collected.
- R10: Bits of `dl_frame` at or above `N_LINKS*RATIO` have no effect on `elink_tx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock, `RATIO` times the frame rate |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | High in the first link-clock cycle of each frame |
| dl_frame | input | DL_W (80) | Downlink frame, sampled with `frame_stb` |
| elink_rx | input | N_LINKS | Serial link inputs, sampled on both edges |
| rx_order | input | N_LINKS | Per-link capture order: 0 rising first, 1 falling first |
| elink_tx | output | N_LINKS | Serial link outputs, single data rate |
| ul_frame | output | UL_W (112) | Assembled uplink frame, held between updates |
| ul_valid | output | 1 | One-cycle pulse when `ul_frame` updates |

## Verification
Each link has its own shift state and edge-order latch. If one link's capture stage holds a wrong value, that link's `2*RATIO`-bit field in `ul_frame` is wrong at the next `ul_valid` pulse, one frame after the bad bit was taken in. The neighbouring fields are unaffected. A fault in the per-link order latch or the falling-edge delay stage shows up only in frames whose order bit selects that path. For this reason the bench changes the order bit at random, including in the middle of frames. A fault in the downlink shift state appears on `elink_tx` in the very next cycle. A fault in the frame-collection flag shows up as a valid pulse at the first strobe after reset.

// File: rtl/elink_bridge_pkg.sv
// Package: shared types and sizing helpers for the link bridge.
// Assumes: callers pass positive widths and a ratio of 1 or 2.
package elink_bridge_pkg;

    // Which clock edge supplies the first bit of a captured pair
    typedef enum logic {
        EDGE_RISE_FIRST = 1'b0,
        EDGE_FALL_FIRST = 1'b1
    } edge_order_e;

    // Number of links an uplink frame can hold at double data rate
    function automatic int link_capacity(input int ul_w, input int ratio);
        return (ul_w + 2 * ratio - 1) / (2 * ratio);
    endfunction

endpackage

// File: rtl/elink_tx_lane.sv
// Module: one downlink serializer lane.
// On a frame strobe it loads the lane's field and drives the field's MSB.
// On the following cycles it shifts out the lower bits, one per cycle,
// then sends zeros until the next strobe.
// Assumes: strobes arrive every RATIO cycles; single data rate output.
module elink_tx_lane #(
    parameter int RATIO = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RATIO-1:0] field,
    output logic             tx
);

    logic [RATIO-1:0] pend_q;   // bits still waiting to be sent
    logic             tx_q;

    // Load a fresh field on a strobe, otherwise shift the pending bits out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            tx_q   <= 1'b0;
        end else if (load) begin
            tx_q   <= field[RATIO-1];
            pend_q <= field << 1;
        end else begin
            tx_q   <= pend_q[RATIO-1];
            pend_q <= pend_q << 1;
        end
    end

    assign tx = tx_q;

endmodule

// File: rtl/elink_rx_lane.sv
// Module: one uplink double-data-rate capture lane.
// The input is sampled on the rising edge and on the falling edge.
// Each cycle one bit pair, earliest bit in the MSB, is formed in the
// order picked for the current frame:
//   rising first : rise(c), fall(c)
//   falling first: fall(c-1), rise(c)
// The pairs are accumulated into a 2*RATIO-bit field. acc_next is the field
// that is complete when the next frame strobe is sampled.
// Assumes: clk has a roughly even duty cycle; rx_bit is already aligned.
module elink_rx_lane
    import elink_bridge_pkg::*;
#(
    parameter int RATIO = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic                 rx_bit,
    input  logic                 order_in,
    output logic [2*RATIO-1:0]   acc_next
);

    localparam int UL_BITS = 2 * RATIO;

    logic        rise_q;    // sample from the rising edge of this cycle
    logic        fall_q;    // sample from the falling edge of this cycle
    logic        fall_d;    // falling sample from one cycle earlier
    edge_order_e order_q;   // order latched at the frame strobe
    logic [1:0]  pair;

    // Rising-edge capture, delayed falling sample, per-frame order latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q  <= 1'b0;
            fall_d  <= 1'b0;
            order_q <= EDGE_RISE_FIRST;
        end else begin
            rise_q <= rx_bit;
            fall_d <= fall_q;
            if (frame_stb) begin
                order_q <= edge_order_e'(order_in);
            end
        end
    end

    // Falling-edge capture
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= rx_bit;
        end
    end

    // Form this cycle's bit pair, earliest bit in the MSB
    always_comb begin
        if (order_q == EDGE_FALL_FIRST) begin
            pair = {fall_d, rise_q};
        end else begin
            pair = {rise_q, fall_q};
        end
    end

    generate
        if (RATIO == 1) begin : g_single
            assign acc_next = pair;
        end else begin : g_multi
            logic [UL_BITS-3:0] hist_q;   // pairs taken earlier in this frame

            // Keep the earlier pairs of the frame, oldest toward the MSB
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else begin
                    hist_q <= acc_next[UL_BITS-3:0];
                end
            end

            assign acc_next = {hist_q, pair};
        end
    endgenerate

endmodule

// File: rtl/elink_ul_packer.sv
// Module: uplink frame register.
// Holds the assembled uplink frame for a whole frame period and pulses
// valid for one cycle when it is replaced. Unassigned upper bits are 0.
// A flag blocks output until one full frame has been collected after reset.
// Assumes: lane fields arrive complete in the cycle frame_stb is sampled.
module elink_ul_packer #(
    parameter int UL_W    = 112,
    parameter int N_LINKS = 56,
    parameter int RATIO   = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_stb,
    input  logic [N_LINKS*2*RATIO-1:0]    lanes,
    output logic [UL_W-1:0]               ul_frame,
    output logic                          ul_valid
);

    localparam int USED = N_LINKS * 2 * RATIO;

    logic            armed_q;    // a frame start has been seen since reset
    logic            valid_q;
    logic [UL_W-1:0] frame_q;
    logic [UL_W-1:0] assembled;

    // Place the lane fields at the bottom and zero-fill the rest
    generate
        if (USED < UL_W) begin : g_pad
            assign assembled = {{(UL_W - USED){1'b0}}, lanes};
        end else begin : g_full
            assign assembled = lanes;
        end
    endgenerate

    // Arm on the first strobe, then latch a frame at every later strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            valid_q <= 1'b0;
            frame_q <= '0;
        end else begin
            valid_q <= frame_stb && armed_q;
            if (frame_stb) begin
                armed_q <= 1'b1;
            end
            if (frame_stb && armed_q) begin
                frame_q <= assembled;
            end
        end
    end

    assign ul_frame = frame_q;
    assign ul_valid = valid_q;

endmodule

// File: rtl/elink_bridge.sv
// Module: top of the link bridge.
// It splits each downlink frame into per-link fields, RATIO bits per link
// taken from dl_frame[k*RATIO +: RATIO], and serializes them MSB first.
// It also captures every link input at double data rate and packs
// 2*RATIO bits per link into the uplink frame.
// Assumes: clk is RATIO times the frame clock; frame_stb marks the first
// cycle of every frame and is regular; N_LINKS*2*RATIO <= UL_W and
// N_LINKS*RATIO <= DL_W.
module elink_bridge
    import elink_bridge_pkg::*;
#(
    parameter int DL_W    = 80,
    parameter int UL_W    = 112,
    parameter int RATIO   = 1,
    parameter int N_LINKS = link_capacity(UL_W, RATIO)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic [DL_W-1:0]      dl_frame,
    input  logic [N_LINKS-1:0]   elink_rx,
    input  logic [N_LINKS-1:0]   rx_order,
    output logic [N_LINKS-1:0]   elink_tx,
    output logic [UL_W-1:0]      ul_frame,
    output logic                 ul_valid
);

    localparam int UL_BITS  = 2 * RATIO;
    localparam int USED_UL  = N_LINKS * UL_BITS;
    localparam int USED_DL  = N_LINKS * RATIO;
    localparam int LINK_CAP = link_capacity(UL_W, RATIO);

    logic [USED_UL-1:0] lane_fields;
    logic [USED_DL-1:0] dl_used;

    // Only the assigned low part of the downlink frame reaches the lanes
    assign dl_used = dl_frame[USED_DL-1:0];

    generate
        for (genvar k = 0; k < N_LINKS; k++) begin : g_link
            elink_tx_lane #(
                .RATIO(RATIO)
            ) u_tx (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (frame_stb),
                .field (dl_used[k*RATIO +: RATIO]),
                .tx    (elink_tx[k])
            );

            elink_rx_lane #(
                .RATIO(RATIO)
            ) u_rx (
                .clk       (clk),
                .rst_n     (rst_n),
                .frame_stb (frame_stb),
                .rx_bit    (elink_rx[k]),
                .order_in  (rx_order[k]),
                .acc_next  (lane_fields[k*UL_BITS +: UL_BITS])
            );
        end
    endgenerate

    elink_ul_packer #(
        .UL_W    (UL_W),
        .N_LINKS (N_LINKS),
        .RATIO   (RATIO)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .lanes     (lane_fields),
        .ul_frame  (ul_frame),
        .ul_valid  (ul_valid)
    );

endmodule

// File: rtl/elink_bridge_chk.sv
// Module: protocol checker for elink_bridge, attached by bind.
// It watches the ports and counts strobes since reset.
module elink_bridge_chk #(
    parameter int DL_W    = 80,
    parameter int UL_W    = 112,
    parameter int RATIO   = 1,
    parameter int N_LINKS = 56
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_stb,
    input logic [DL_W-1:0]      dl_frame,
    input logic [N_LINKS-1:0]   elink_tx,
    input logic [UL_W-1:0]      ul_frame,
    input logic                 ul_valid
);

    logic [1:0]         stb_seen;     // strobes since reset, saturating at 2
    logic [N_LINKS-1:0] first_bits;   // field MSBs of the current dl_frame

    // Count strobes since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_seen <= 2'd0;
        end else if (frame_stb && stb_seen != 2'd2) begin
            stb_seen <= stb_seen + 2'd1;
        end
    end

    // Pick the leading bit of each link's field
    always_comb begin
        for (int k = 0; k < N_LINKS; k++) begin
            first_bits[k] = dl_frame[k*RATIO + RATIO - 1];
        end
    end

    // R8: a valid pulse only follows a sampled strobe
    assert_valid_follows_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ul_valid |-> $past(frame_stb));

    // R8: the uplink frame holds while no valid pulse is shown
    assert_frame_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ul_valid |-> $stable(ul_frame));

    // R9: no valid pulse before a full frame has been collected
    assert_no_early_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ul_valid |-> (stb_seen == 2'd2));

    // R2: the cycle after a strobe drives every field's MSB
    assert_tx_leading_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (elink_tx == $past(first_bits)));

    // R3: outputs stay quiet until the first strobe after reset
    assert_tx_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_seen == 2'd0) |-> (elink_tx == '0));

endmodule

bind elink_bridge elink_bridge_chk #(
    .DL_W    (DL_W),
    .UL_W    (UL_W),
    .RATIO   (RATIO),
    .N_LINKS (N_LINKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .dl_frame  (dl_frame),
    .elink_tx  (elink_tx),
    .ul_frame  (ul_frame),
    .ul_valid  (ul_valid)
);

// File: tb/tb_elink_bridge.sv
// Bench for elink_bridge at RATIO = 2 with fewer links than capacity.
// Stimulus is seeded random, mixed with directed corner frames.
// Expected values come from per-cycle histories of the driven inputs.
module tb_elink_bridge;

    localparam int  CLK_PERIOD = 10;
    localparam int  DL_W  = 80;
    localparam int  UL_W  = 112;
    localparam int  RATIO = 2;
    localparam int  LINKS = 26;
    localparam int  UB    = 2 * RATIO;
    localparam int  HIST  = 4096;
    localparam int  CAP   = (UL_W + UB - 1) / UB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_stb = 1'b0;
    logic [DL_W-1:0]   dl_frame = '0;
    logic [LINKS-1:0]  elink_rx = '0;
    logic [LINKS-1:0]  rx_order = '0;
    logic [LINKS-1:0]  elink_tx;
    logic [UL_W-1:0]   ul_frame;
    logic              ul_valid;

    elink_bridge #(
        .DL_W(DL_W), .UL_W(UL_W), .RATIO(RATIO), .N_LINKS(LINKS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .dl_frame(dl_frame),
        .elink_rx(elink_rx), .rx_order(rx_order), .elink_tx(elink_tx),
        .ul_frame(ul_frame), .ul_valid(ul_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // driven histories, indexed by cycle
    logic [LINKS-1:0] rise_h  [0:HIST-1];
    logic [LINKS-1:0] fall_h  [0:HIST-1];
    logic [LINKS-1:0] order_h [0:HIST-1];

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    bit  done   = 0;

    // model state
    logic             exp_valid = 1'b0;
    logic [UL_W-1:0]  exp_ul    = '0;
    logic [LINKS-1:0] exp_tx    = '0;
    bit               seen      = 0;
    int               last_s    = 0;
    int               pos       = 0;
    logic [DL_W-1:0]  last_dl   = '0;

    function automatic logic [DL_W-1:0] rand_dl();
        logic [DL_W-1:0] v;
        v = '0;
        for (int i = 0; i < DL_W; i += 16) v[i +: 16] = 16'($urandom);
        return v;
    endfunction

    // R4 R5 R7: expected uplink frame for a frame starting in cycle s
    function automatic logic [UL_W-1:0] calc_ul(input int s);
        logic [UL_W-1:0] f;
        f = '0;
        for (int k = 0; k < LINKS; k++) begin
            for (int i = 0; i < UB; i++) begin
                logic b;
                if (order_h[s][k] == 1'b0)
                    b = (i % 2 == 0) ? rise_h[s + i/2][k] : fall_h[s + i/2][k];
                else
                    b = (i % 2 == 0) ? fall_h[s + i/2 - 1][k] : rise_h[s + (i-1)/2][k];
                f[k*UB + UB - 1 - i] = b;
            end
        end
        return f;
    endfunction

    // Compare all outputs with the model
    task automatic check_outputs();
        checks++;
        if (ul_valid !== exp_valid) begin
            fails++;
            $display("FAIL R8 R9 ul_valid cyc %0d: got %b exp %b", cyc, ul_valid, exp_valid);
        end
        checks++;
        if (ul_frame !== exp_ul) begin
            fails++;
            $display("FAIL R4 R5 R6 R7 ul_frame cyc %0d: got %h exp %h", cyc, ul_frame, exp_ul);
        end
        checks++;
        if (elink_tx !== exp_tx) begin
            fails++;
            $display("FAIL R2 R3 R10 elink_tx cyc %0d: got %h exp %h", cyc, elink_tx, exp_tx);
        end
    endtask

    // One link-clock cycle: check, drive, then update the model
    task automatic step(input logic rst, input logic stb, input logic [DL_W-1:0] dl,
                        input logic [LINKS-1:0] ord, input logic [LINKS-1:0] r,
                        input logic [LINKS-1:0] f);
        @(negedge clk);
        if (cyc > 0) check_outputs();
        #1;
        rst_n = rst; frame_stb = stb; dl_frame = dl; rx_order = ord; elink_rx = r;
        rise_h[cyc]  = rst ? r : '0;
        order_h[cyc] = ord;
        @(posedge clk);
        #1;
        elink_rx = f;
        fall_h[cyc] = rst ? f : '0;
        if (!rst) begin
            exp_valid = 1'b0; exp_ul = '0; exp_tx = '0; seen = 0; pos = RATIO;
        end else begin
            exp_valid = stb && seen;
            if (exp_valid) exp_ul = calc_ul(last_s);
            if (stb) begin
                seen = 1; last_s = cyc; last_dl = dl; pos = 0;
            end else if (seen) begin
                pos++;
            end
            for (int k = 0; k < LINKS; k++)
                exp_tx[k] = (seen && pos < RATIO) ? last_dl[k*RATIO + RATIO - 1 - pos] : 1'b0;
        end
        cyc++;
    endtask

    // One whole frame; R6: order is re-randomized in the non-strobe cycles
    task automatic run_frame(input logic [DL_W-1:0] dl, input logic [LINKS-1:0] ord,
                             input bit rnd_rx, input logic [LINKS-1:0] rc,
                             input logic [LINKS-1:0] fc);
        for (int i = 0; i < RATIO; i++) begin
            logic [LINKS-1:0] o;
            logic [LINKS-1:0] r;
            logic [LINKS-1:0] f;
            o = (i == 0) ? ord : LINKS'($urandom);
            r = rnd_rx ? LINKS'($urandom) : rc;
            f = rnd_rx ? LINKS'($urandom) : fc;
            step(1'b1, i == 0, dl, o, r, f);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0a17);

        // R1: default link count follows the ceiling formula
        checks++;
        if (CAP != 28 || dut.LINK_CAP != CAP) begin
            fails++;
            $display("FAIL R1 link capacity: got %0d exp %0d", dut.LINK_CAP, 28);
        end

        // R9: reset state, then idle cycles (R3: tx stays 0 without strobe)
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, rand_dl(), '0, '0, '0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, rand_dl(), '0, LINKS'($urandom), LINKS'($urandom));

        // directed corners: all-ones and alternating patterns in both orders
        run_frame({DL_W{1'b1}}, '0, 0, '1, '0);
        run_frame('0, '1, 0, '1, '0);
        run_frame({40{2'b10}}, '0, 0, '0, '1);
        run_frame({40{2'b01}}, '1, 0, '0, '1);
        run_frame({DL_W{1'b1}}, {13{2'b10}}, 0, '1, '1);

        // random traffic; R10: upper dl bits are random too
        for (int n = 0; n < 400; n++)
            run_frame(rand_dl(), LINKS'($urandom), 1, '0, '0);

        // R9: reset in mid-stream, then resume
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, rand_dl(), '0, LINKS'($urandom), LINKS'($urandom));
        step(1'b1, 1'b0, '0, '0, LINKS'($urandom), LINKS'($urandom));
        for (int n = 0; n < 200; n++)
            run_frame(rand_dl(), LINKS'($urandom), 1, '0, '0);

        @(negedge clk);
        check_outputs();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule